// File: doc/BRIEF.md
# Program-Row Load Buffer

This block stages one row of program-memory data ahead of a row programming cycle. Software-side logic issues single-word loads. Each load carries a word address, a flag that picks the low 16-bit half or the high 8-bit half of a 24-bit instruction, and a 16-bit data value. The buffer holds 64 instruction words. The programming controller reads each word back through a combinational read port and takes the row number from `row_base`.

The word address splits into two fields. The low six bits index the instruction inside the row. The remaining bits name the row, so rows start on 64-instruction boundaries from address zero. Loads must fill the row strictly in order: low half of word 0, high half of word 0, low half of word 1, and so on up to the high half of word 63.

Any load that breaks this order is ignored and sets a sticky error flag. A load also breaks the order if it names a row other than the one the first load opened. Once all 128 halves are in, `row_full` rises. A `prog_done` pulse from the controller empties the buffer for the next row.

Top module: `row_load_buffer`

## Requirements
- R1: After reset, `row_full`, `seq_err` and `ld_done` are 0 and every word read through `rd_idx` is 0.
- R2: The first accepted load of a row must be the low half (`ld_hi`=0) of index 0. Its row field, `ld_addr[15:6]`, appears on `row_base` from the next cycle on. A first load to any other position is rejected.
- R3: The instruction index is `ld_addr[5:0]`. A low-half load stores `ld_data[15:0]` into bits 15:0 of that word. A high-half load (`ld_hi`=1) stores `ld_data[7:0]` into bits 23:16, and `ld_data[15:8]` has no effect.
- R4: Loads are accepted only in the order index*2+`ld_hi` = number of halves already accepted. Each accepted load updates the stored word at the next clock edge.
- R5: A load is rejected in either of two cases: its position is not the next one expected, or, after the first accepted load, its row field differs from `row_base`. A rejected load leaves the stored words, the fill progress and `row_base` unchanged, and `seq_err` is 1 from the next cycle. An earlier error does not block later correct loads.
- R6: `seq_err` stays 1 until a `prog_done` pulse.
- R7: `row_full` becomes 1 in the cycle after the 128th accepted load, which is the high half of index 63. While it is 1, every load is rejected.
- R8: Every load completes in two cycles: `ld_done` is 1 in the cycle after `ld_valid` was 1 (accepted or not), and 0 otherwise.
- R9: `prog_done` clears all stored words to 0 and clears the fill progress, `row_base`, `row_full` and `seq_err`. A load presented in the same cycle is ignored and does not set `seq_err`.
- R10: `rd_data` shows the stored 24-bit word selected by `rd_idx` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_addr | input | 16 | Instruction word address: row field and index |
| ld_hi | input | 1 | 1 selects the high 8-bit half, 0 the low 16-bit half |
| ld_data | input | 16 | Load data |
| prog_done | input | 1 | Row programming finished; empties the buffer |
| rd_idx | input | 6 | Word index for the read port |
| rd_data | output | 24 | Stored word at `rd_idx` |
| row_full | output | 1 | All 128 halves of the row have been accepted |
| seq_err | output | 1 | Sticky flag for a rejected load |
| row_base | output | 10 | Row number latched by the first accepted load |
| ld_done | output | 1 | Load completion, one cycle after `ld_valid` |

## Verification
The bench drives whole rows with random data and slips in out-of-order loads and loads to the wrong row. If the design wrongly accepted one of these, the read-back of the stored words would differ from the model. If it wrongly rejected a correct load, `row_full` would never rise. The bench covers four corner cases:
- a first load that starts at a nonzero position;
- a load sent after the row is full, which a design that wraps its counter would store;
- a load in the same cycle as `prog_done`, which a design that orders these two wrongly would keep or flag;
- high-half loads with junk in the upper data bits, which a design with the wrong field position would write into the stored word.

// File: rtl/row_load_pkg.sv
package row_load_pkg;
    localparam int LO_W   = 16;
    localparam int HI_W   = 8;
    localparam int WORD_W = LO_W + HI_W;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/row_seq_check.sv
module row_seq_check #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 8,
    localparam int ROW_W = ADDR_W - IDX_W
) (
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [ROW_W-1:0]  base_q,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_hi,
    input  logic              clear,
    output logic              accept,
    output logic              reject,
    output logic [ROW_W-1:0]  ld_row
);
    import row_load_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(2 << IDX_W);

    logic [IDX_W:0] pos;
    logic           at_start;
    logic           is_full;
    logic           order_ok;

    always_comb begin
        ld_row   = ld_addr[ADDR_W-1:IDX_W];
        pos      = {ld_addr[IDX_W-1:0], (half_e'(ld_hi) == HALF_HI)};
        at_start = (cnt_q == '0);
        is_full  = (cnt_q == FULL_CNT);
        order_ok = !is_full
                 && (CNT_W'(pos) == cnt_q)
                 && (at_start || (ld_row == base_q));
        accept   = ld_valid && !clear && order_ok;
        reject   = ld_valid && !clear && !order_ok;
    end
endmodule

// File: rtl/row_word_store.sv
module row_word_store #(
    parameter int ROW_WORDS = 64,
    parameter int IDX_W     = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           wr_hi,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [row_load_pkg::LO_W-1:0]  wr_data,
    input  logic                           clear,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [row_load_pkg::WORD_W-1:0] rd_data
);
    import row_load_pkg::*;

    logic [WORD_W-1:0] word_arr [ROW_WORDS];

    for (genvar w = 0; w < ROW_WORDS; w++) begin : g_word
        logic [LO_W-1:0] lo_d, lo_q;
        logic [HI_W-1:0] hi_d, hi_q;

        always_comb begin
            lo_d = lo_q;
            hi_d = hi_q;
            if (clear) begin
                lo_d = '0;
                hi_d = '0;
            end else if (wr_en && (wr_idx == IDX_W'(w))) begin
                if (wr_hi) hi_d = wr_data[HI_W-1:0];
                else       lo_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else begin
                lo_q <= lo_d;
                hi_q <= hi_d;
            end
        end

        assign word_arr[w] = {hi_q, lo_q};
    end

    always_comb begin
        if (int'(rd_idx) < ROW_WORDS) rd_data = word_arr[rd_idx];
        else                          rd_data = '0;
    end
endmodule

// File: rtl/row_load_buffer.sv
module row_load_buffer #(
    parameter int ADDR_W    = 16,
    parameter int ROW_WORDS = 64,
    localparam int IDX_W    = $clog2(ROW_WORDS),
    localparam int ROW_W    = ADDR_W - IDX_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ld_valid,
    input  logic [ADDR_W-1:0]               ld_addr,
    input  logic                            ld_hi,
    input  logic [row_load_pkg::LO_W-1:0]   ld_data,
    input  logic                            prog_done,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [row_load_pkg::WORD_W-1:0] rd_data,
    output logic                            row_full,
    output logic                            seq_err,
    output logic [ROW_W-1:0]                row_base,
    output logic                            ld_done
);
    localparam int CNT_W = IDX_W + 2;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(2 * ROW_WORDS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] base;
        logic             err;
        logic             done;
    } state_t;

    state_t s_d, s_q;

    logic             accept;
    logic             reject;
    logic [ROW_W-1:0] ld_row;

    row_seq_check #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) seq_i (
        .cnt_q    (s_q.cnt),
        .base_q   (s_q.base),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ld_hi    (ld_hi),
        .clear    (prog_done),
        .accept   (accept),
        .reject   (reject),
        .ld_row   (ld_row)
    );

    row_word_store #(
        .ROW_WORDS (ROW_WORDS),
        .IDX_W     (IDX_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_hi   (ld_hi),
        .wr_idx  (ld_addr[IDX_W-1:0]),
        .wr_data (ld_data),
        .clear   (prog_done),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = ld_valid;
        if (prog_done) begin
            s_d.cnt  = '0;
            s_d.base = '0;
            s_d.err  = 1'b0;
        end else if (accept) begin
            if (s_q.cnt == '0) s_d.base = ld_row;
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (reject) begin
            s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign row_full = (s_q.cnt == FULL_CNT);
    assign seq_err  = s_q.err;
    assign row_base = s_q.base;
    assign ld_done  = s_q.done;
endmodule

// File: rtl/row_load_buffer_checker.sv
module row_load_buffer_checker #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6,
    localparam int ROW_W = ADDR_W - IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              ld_hi,
    input logic              prog_done,
    input logic              row_full,
    input logic              seq_err,
    input logic [ROW_W-1:0]  row_base,
    input logic              ld_done
);
    assert_done_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !ld_done);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !prog_done) |=> seq_err);

    assert_err_needs_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(ld_valid && !prog_done));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |=> (!row_full && !seq_err && row_base == '0));

    assert_full_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_full) |-> $past(ld_valid && ld_hi && !prog_done
                                  && ld_addr[IDX_W-1:0] == {IDX_W{1'b1}}));

    assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_full && !prog_done) |=> (row_full && $stable(row_base)));
endmodule

bind row_load_buffer row_load_buffer_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_addr   (ld_addr),
    .ld_hi     (ld_hi),
    .prog_done (prog_done),
    .row_full  (row_full),
    .seq_err   (seq_err),
    .row_base  (row_base),
    .ld_done   (ld_done)
);

// File: tb/row_load_buffer_tb_top.sv
module row_load_buffer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int WORDS      = 64;
    localparam int IDX_W      = 6;
    localparam int ROW_W      = ADDR_W - IDX_W;
    localparam int FULL       = 2 * WORDS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              ld_hi = 1'b0;
    logic [15:0]       ld_data = '0;
    logic              prog_done = 1'b0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [23:0]       rd_data;
    logic              row_full;
    logic              seq_err;
    logic [ROW_W-1:0]  row_base;
    logic              ld_done;

    int checks = 0;
    int errors = 0;

    logic [23:0]      m_word [WORDS];
    int               m_cnt;
    logic [ROW_W-1:0] m_base;
    bit               m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    row_load_buffer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_hi     (ld_hi),
        .ld_data   (ld_data),
        .prog_done (prog_done),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .row_full  (row_full),
        .seq_err   (seq_err),
        .row_base  (row_base),
        .ld_done   (ld_done)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit model_accept(logic [ADDR_W-1:0] a, logic h);
        int pos = int'(a[IDX_W-1:0]) * 2 + int'(h);
        if (m_cnt == FULL) return 1'b0;
        if (pos != m_cnt) return 1'b0;
        if (m_cnt != 0 && a[ADDR_W-1:IDX_W] != m_base) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < WORDS; i++) m_word[i] = '0;
        m_cnt  = 0;
        m_base = '0;
        m_err  = 1'b0;
    endtask

    task automatic check_flags(string req);
        check({req, " seq_err"}, 32'(seq_err), 32'(m_err));
        check({req, " row_full"}, 32'(row_full), 32'(m_cnt == FULL));
        check({req, " row_base"}, 32'(row_base), 32'(m_base));
    endtask

    task automatic do_load(logic [ADDR_W-1:0] a, logic h, logic [15:0] d, string req);
        bit ok;
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_hi = h; ld_data = d;
        ok = model_accept(a, h);
        @(negedge clk);
        ld_valid = 1'b0;
        if (ok) begin
            if (h) m_word[a[IDX_W-1:0]][23:16] = d[7:0];
            else   m_word[a[IDX_W-1:0]][15:0]  = d;
            if (m_cnt == 0) m_base = a[ADDR_W-1:IDX_W];
            m_cnt++;
        end else begin
            m_err = 1'b1;
        end
        check({req, " R8 ld_done"}, 32'(ld_done), 32'd1);
        check_flags(req);
    endtask

    task automatic do_clear(bit with_load);
        @(negedge clk);
        prog_done = 1'b1;
        if (with_load) begin
            ld_valid = 1'b1; ld_addr = '0; ld_hi = 1'b0; ld_data = 16'h5a5a;
        end
        @(negedge clk);
        prog_done = 1'b0;
        ld_valid  = 1'b0;
        model_clear();
        check("R9 clear done", 32'(ld_done), 32'(with_load));
        check_flags("R9 clear");
    endtask

    task automatic verify_words(string req);
        for (int i = 0; i < WORDS; i++) begin
            rd_idx = IDX_W'(i);
            #1;
            check({req, " R10 rd_data"}, 32'(rd_data), 32'(m_word[i]));
        end
    endtask

    task automatic fill_row(logic [ROW_W-1:0] row, int bad_rate, string req);
        for (int p = 0; p < FULL; p++) begin
            if (bad_rate != 0 && ($urandom % bad_rate) == 0) begin
                do_load(ADDR_W'($urandom), 1'($urandom), 16'($urandom), {req, " R5 bad"});
            end
            do_load({row, IDX_W'(p / 2)}, 1'(p % 2), 16'($urandom), {req, " R4"});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 ld_done", 32'(ld_done), 32'd0);
        check_flags("R1");
        verify_words("R1");

        // R2: a first load that does not start at index 0 low half
        do_load({10'd5, 6'd1}, 1'b0, 16'h1111, "R2 first at idx1");
        do_load({10'd5, 6'd0}, 1'b1, 16'h2222, "R2 first at hi half");
        // R6: flag survives a later correct load
        do_load({10'd5, 6'd0}, 1'b0, 16'h3333, "R6 sticky after good load");
        verify_words("R2");
        do_clear(1'b0);
        verify_words("R9");

        // R8: idle cycle drops ld_done
        @(negedge clk);
        check("R8 idle", 32'(ld_done), 32'd0);

        // R3: high half with junk in the upper data bits
        do_load({10'd9, 6'd0}, 1'b0, 16'hbeef, "R3 low");
        do_load({10'd9, 6'd0}, 1'b1, 16'hff42, "R3 high");
        // R5: wrong row, then skipped position
        do_load({10'd8, 6'd1}, 1'b0, 16'h7777, "R5 wrong row");
        do_load({10'd9, 6'd2}, 1'b0, 16'h8888, "R5 skip");
        verify_words("R3");
        check("R3 stored word", 32'(m_word[0]), 32'h42beef);
        do_clear(1'b0);

        // R7: full row, then a load past the end
        fill_row(10'h2a5, 0, "R7 directed");
        check("R7 full", 32'(row_full), 32'd1);
        do_load({10'h2a5, 6'd0}, 1'b0, 16'hdead, "R7 load when full");
        verify_words("R7");

        // R9: clear with a simultaneous load
        do_clear(1'b1);
        verify_words("R9 same-cycle load");
        do_load({10'd3, 6'd0}, 1'b0, 16'h0102, "R9 restart");
        do_clear(1'b0);

        // random rows with injected bad loads
        for (int r = 0; r < 3; r++) begin
            fill_row(ROW_W'($urandom), 6, "rand");
            verify_words("R4 rand");
            do_clear(1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule